// File: doc/BRIEF.md
# RV64 Doubleword and Unsigned-Word Load/Store Unit

This unit executes three 64-bit memory instructions: the doubleword load, the unsigned word load and the doubleword store. It accepts one instruction word at a time together with the base register value and, for stores, the data register value. It decodes the word and forms the effective address by adding the base to a sign-extended 12-bit offset. It then issues one access on a simple 64-bit data-memory port with per-byte enables.

When a load finishes, the unit returns writeback data and the destination register index. Full-width loads return all 64 bits. Unsigned word loads return the selected 32-bit lane with zeros above it. Accesses that are not naturally aligned end in a misaligned flag. Instruction words outside the three supported forms end in an illegal flag. Neither of these faults reaches memory.

The memory port uses a request/grant handshake. The request and all its fields stay steady until the grant arrives. Read data must be presented on the cycle after the grant. Every instruction ends with a single-cycle `done` pulse, which carries its outcome.

Top module: `rv64_dw_lsu`

## Requirements
- R1: During and after reset, `issue_ready` is 1. `mem_req`, `done`, `wb_valid`, `fault_misaligned` and `fault_illegal` are all 0.
- R2: An instruction with opcode bits[6:0] = 0000011 and bits[14:12] = 011 reads the 64-bit word at `issue_base` plus sign-extended bits[31:20]. The request has `mem_we` = 0 and `mem_be` = 8'hFF. It completes with `wb_valid` = 1, `wb_data` equal to the full read word, and `wb_rd` equal to bits[11:7].
- R3: An instruction with opcode bits[6:0] = 0000011 and bits[14:12] = 110 reads one 32-bit lane. When address bit 2 is 0, `mem_be` = 8'h0F and `wb_data` = {32'b0, `mem_rdata`[31:0]}. When address bit 2 is 1, `mem_be` = 8'hF0 and `wb_data` = {32'b0, `mem_rdata`[63:32]}. No sign extension is applied.
- R4: An instruction with opcode bits[6:0] = 0100011 and bits[14:12] = 011 writes `issue_data` to address `issue_base` + sign-extended {bits[31:25], bits[11:7]}. The request has `mem_we` = 1 and `mem_be` = 8'hFF. It completes with `done` and `wb_valid` = 0.
- R5: The offset is sign-extended from its bit 11, so an offset with bit 11 set lowers the address below the base.
- R6: A doubleword access with address[2:0] != 0, or a word access with address[1:0] != 0, produces `done` with `fault_misaligned` = 1. No memory request is raised.
- R7: Any other funct3 value under either opcode, or any other opcode, produces `done` with `fault_illegal` = 1. No memory request is raised, and the illegal check takes priority over the alignment check.
- R8: `issue_ready` is low from acceptance until the cycle `done` rises, and `issue_valid` has no effect in that window. While `mem_req` waits for `mem_gnt`, the address, byte enables, write data and write strobe stay unchanged. Read data is sampled on the cycle after the grant.
- R9: Counted in clock edges after the issue edge, `done` appears after 1 edge for a fault, 2 + G for a store and 3 + G for a load, where G is the number of cycles the grant is withheld. At most one of `wb_valid`, `fault_misaligned` and `fault_illegal` is set, and only with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An instruction is offered |
| issue_ready | output | 1 | Unit is idle and takes the offered instruction |
| issue_instr | input | 32 | Instruction word |
| issue_base | input | 64 | Base register value |
| issue_data | input | 64 | Store data register value |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 64 | Byte address of the access |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after the grant |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Load result present, with `done` |
| wb_rd | output | 5 | Destination register index |
| wb_data | output | 64 | Load result |
| fault_misaligned | output | 1 | Alignment fault, with `done` |
| fault_illegal | output | 1 | Unsupported instruction, with `done` |

## Verification
The handshake assertions assume that memory returns valid read data exactly one cycle after the grant. They also assume that `mem_gnt` is raised only while `mem_req` is high. The bench memory model meets both conditions: it registers its read word on the granting edge, and it derives the grant from the request and a programmable stall count.

The assertions also rely on issue inputs being sampled only while the unit is idle. To test R8, the bench deliberately holds a conflicting store on the issue inputs while the unit is busy. It then confirms through memory contents and the request count that the store never took effect.

// File: rtl/lsu_pkg.sv
// Package: shared encodings and types for the doubleword load/store unit.
// Assumes a 32-bit instruction word; opcode and funct3 values are fixed
// by the instruction set and are not parameters.
package lsu_pkg;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [2:0] F3_DWORD  = 3'b011;
    localparam logic [2:0] F3_UWORD  = 3'b110;

    // Operation kinds after decode.
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LDD  = 2'd1,
        OP_LDW  = 2'd2,
        OP_STD  = 2'd3
    } lsu_op_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } lsu_state_e;

    // Decoded instruction fields.
    typedef struct packed {
        lsu_op_e     op;
        logic        illegal;
        logic [4:0]  rd;
        logic [11:0] offset;
    } lsu_dec_t;

endpackage

// File: rtl/lsu_decode.sv
// Module: lsu_decode
// Classifies a 32-bit instruction word into one of the three supported
// memory operations and extracts the destination index and the 12-bit
// offset (contiguous for loads, split across two fields for stores).
// Assumes: purely combinational; anything not recognised is illegal.
module lsu_decode
    import lsu_pkg::*;
(
    input  logic [31:0] instr,
    output lsu_dec_t    dec
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic       unused_regidx;

    assign opcode        = instr[6:0];
    assign funct3        = instr[14:12];
    // Register index fields are resolved upstream; only values arrive here.
    assign unused_regidx = ^instr[24:15];

    // Decide the operation and pick the offset layout matching it.
    always_comb begin
        dec.op      = OP_NONE;
        dec.illegal = 1'b1;
        dec.rd      = instr[11:7];
        dec.offset  = instr[31:20];
        if (opcode == OPC_LOAD) begin
            if (funct3 == F3_DWORD) begin
                dec.op      = OP_LDD;
                dec.illegal = 1'b0;
            end else if (funct3 == F3_UWORD) begin
                dec.op      = OP_LDW;
                dec.illegal = 1'b0;
            end
        end else if (opcode == OPC_STORE) begin
            dec.offset = {instr[31:25], instr[11:7]};
            if (funct3 == F3_DWORD) begin
                dec.op      = OP_STD;
                dec.illegal = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lsu_agen.sv
// Module: lsu_agen
// Forms the effective byte address from a base value and a sign-extended
// 12-bit offset, derives per-byte enables for the access width, and flags
// accesses that are not naturally aligned.
// Assumes: XLEN is 64; the word lane is chosen by address bit 2.
module lsu_agen
    import lsu_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int OFF_W = 12
) (
    input  logic [XLEN-1:0]   base,
    input  logic [OFF_W-1:0]  offset,
    input  lsu_op_e           op,
    output logic [XLEN-1:0]   addr,
    output logic [XLEN/8-1:0] be,
    output logic              misaligned
);

    localparam int BE_W    = XLEN / 8;
    localparam int DW_LSB  = $clog2(BE_W);
    localparam int WORD_BE = 4;

    logic is_dword;
    logic is_word;

    assign is_dword = (op == OP_LDD) || (op == OP_STD);
    assign is_word  = (op == OP_LDW);

    // Base plus offset with the offset sign-extended to full width.
    always_comb begin
        addr = base + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
    end

    // Natural alignment check per access width.
    always_comb begin
        misaligned = 1'b0;
        if (is_dword && (addr[DW_LSB-1:0] != '0)) misaligned = 1'b1;
        if (is_word  && (addr[1:0] != 2'b00))     misaligned = 1'b1;
    end

    // One enable per byte lane: all for doublewords, one half for words.
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        localparam logic UPPER = ((g / WORD_BE) % 2) == 1;
        assign be[g] = is_dword || (is_word && (addr[2] == UPPER));
    end

endmodule

// File: rtl/lsu_ctrl.sv
// Module: lsu_ctrl
// Sequences one memory instruction at a time: takes a decoded command,
// raises a fault immediately or holds a request until granted, captures
// read data the cycle after the grant, and formats it for writeback.
// Assumes: memory presents read data exactly one cycle after mem_gnt,
// and mem_gnt is only raised while mem_req is high.
module lsu_ctrl
    import lsu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  lsu_op_e           op,
    input  logic              illegal,
    input  logic              misaligned,
    input  logic [4:0]        rd,
    input  logic [XLEN-1:0]   addr,
    input  logic [XLEN/8-1:0] be,
    input  logic [XLEN-1:0]   wdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              done,
    output logic              wb_valid,
    output logic [4:0]        wb_rd,
    output logic [XLEN-1:0]   wb_data,
    output logic              fault_misaligned,
    output logic              fault_illegal
);

    localparam int BE_W = XLEN / 8;
    localparam int W    = 32;

    lsu_state_e        state;
    logic              cmd_we;
    logic              cmd_word;
    logic [XLEN-1:0]   cmd_addr;
    logic [BE_W-1:0]   cmd_be;
    logic [XLEN-1:0]   cmd_wdata;
    logic [4:0]        cmd_rd;
    logic [XLEN-1:0]   load_fmt;
    logic              done_q;
    logic              wbv_q;
    logic              mis_q;
    logic              ill_q;
    logic              res_word_q;
    logic [XLEN-1:0]   wb_data_q;
    logic              take;

    assign issue_ready = (state == ST_IDLE);
    assign take        = issue_ready && issue_valid && !illegal && !misaligned;

    // Sequencer: idle -> request -> (wait for read data) -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (take) state <= ST_REQ;
                ST_REQ:  if (mem_gnt) state <= cmd_we ? ST_IDLE : ST_WAIT;
                ST_WAIT: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command capture on acceptance; held steady for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_we    <= 1'b0;
            cmd_word  <= 1'b0;
            cmd_addr  <= '0;
            cmd_be    <= '0;
            cmd_wdata <= '0;
            cmd_rd    <= '0;
        end else if (take) begin
            cmd_we    <= (op == OP_STD);
            cmd_word  <= (op == OP_LDW);
            cmd_addr  <= addr;
            cmd_be    <= be;
            cmd_wdata <= wdata;
            cmd_rd    <= rd;
        end
    end

    // Writeback formatting: full word, or chosen lane zero-extended.
    always_comb begin
        if (cmd_word) begin
            load_fmt = {{(XLEN-W){1'b0}},
                        (cmd_addr[2] ? mem_rdata[2*W-1:W] : mem_rdata[W-1:0])};
        end else begin
            load_fmt = mem_rdata;
        end
    end

    // Completion pulses and the load result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            wbv_q      <= 1'b0;
            mis_q      <= 1'b0;
            ill_q      <= 1'b0;
            res_word_q <= 1'b0;
            wb_data_q  <= '0;
        end else begin
            done_q <= 1'b0;
            wbv_q  <= 1'b0;
            mis_q  <= 1'b0;
            ill_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (issue_valid && illegal) begin
                        done_q <= 1'b1;
                        ill_q  <= 1'b1;
                    end else if (issue_valid && misaligned) begin
                        done_q <= 1'b1;
                        mis_q  <= 1'b1;
                    end
                end
                ST_REQ: begin
                    if (mem_gnt && cmd_we) done_q <= 1'b1;
                end
                ST_WAIT: begin
                    done_q     <= 1'b1;
                    wbv_q      <= 1'b1;
                    res_word_q <= cmd_word;
                    wb_data_q  <= load_fmt;
                end
                default: ;
            endcase
        end
    end

    assign mem_req          = (state == ST_REQ);
    assign mem_we           = cmd_we;
    assign mem_addr         = cmd_addr;
    assign mem_be           = cmd_be;
    assign mem_wdata        = cmd_wdata;
    assign done             = done_q;
    assign wb_valid         = wbv_q;
    assign wb_rd            = cmd_rd;
    assign wb_data          = wb_data_q;
    assign fault_misaligned = mis_q;
    assign fault_illegal    = ill_q;

    // R1: nothing is requested in the first cycle after reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !mem_req && !done);

    // R8: a pending request keeps every field steady until granted.
    p_hold_until_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_be)
                                && $stable(mem_wdata) && $stable(mem_we));

    // R4: every write enables all byte lanes.
    p_store_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> (mem_be == {BE_W{1'b1}}));

    // R6: a request never carries a misaligned address for its width.
    p_request_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)
                    && (!(&mem_be) || (mem_addr[2:0] == 3'b000)));

    // R9: at most one outcome, and only together with done.
    p_single_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid, fault_misaligned, fault_illegal})
        && ((wb_valid || fault_misaligned || fault_illegal) -> done));

    // R8: a load result follows a grant of a read two edges earlier.
    p_result_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt && !mem_we |=> !done ##1 (done && wb_valid));

    // R3: word results have nothing above bit 31.
    p_word_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && res_word_q |-> (wb_data[XLEN-1:W] == '0));

    // R8: done is only raised once the unit is free again.
    p_done_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> issue_ready && !mem_req);

endmodule

// File: rtl/rv64_dw_lsu.sv
// Module: rv64_dw_lsu (top)
// Load/store unit for doubleword load, unsigned word load and doubleword
// store. Wires decode, address generation and the access sequencer.
// Assumes: one instruction in flight; memory answers reads one cycle
// after the grant.
module rv64_dw_lsu
    import lsu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [31:0]       issue_instr,
    input  logic [XLEN-1:0]   issue_base,
    input  logic [XLEN-1:0]   issue_data,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN/8-1:0] mem_be,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              done,
    output logic              wb_valid,
    output logic [4:0]        wb_rd,
    output logic [XLEN-1:0]   wb_data,
    output logic              fault_misaligned,
    output logic              fault_illegal
);

    localparam int BE_W  = XLEN / 8;
    localparam int OFF_W = 12;

    lsu_dec_t        dec;
    logic [XLEN-1:0] ea;
    logic [BE_W-1:0] ea_be;
    logic            ea_mis;

    lsu_decode u_decode (
        .instr (issue_instr),
        .dec   (dec)
    );

    lsu_agen #(.XLEN(XLEN), .OFF_W(OFF_W)) u_agen (
        .base       (issue_base),
        .offset     (dec.offset),
        .op         (dec.op),
        .addr       (ea),
        .be         (ea_be),
        .misaligned (ea_mis)
    );

    lsu_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .issue_valid      (issue_valid),
        .issue_ready      (issue_ready),
        .op               (dec.op),
        .illegal          (dec.illegal),
        .misaligned       (ea_mis),
        .rd               (dec.rd),
        .addr             (ea),
        .be               (ea_be),
        .wdata            (issue_data),
        .mem_req          (mem_req),
        .mem_gnt          (mem_gnt),
        .mem_we           (mem_we),
        .mem_addr         (mem_addr),
        .mem_be           (mem_be),
        .mem_wdata        (mem_wdata),
        .mem_rdata        (mem_rdata),
        .done             (done),
        .wb_valid         (wb_valid),
        .wb_rd            (wb_rd),
        .wb_data          (wb_data),
        .fault_misaligned (fault_misaligned),
        .fault_illegal    (fault_illegal)
    );

endmodule

// File: tb/rv64_dw_lsu_test.sv
// Directed bench for rv64_dw_lsu with a 16-doubleword behavioural memory.
module rv64_dw_lsu_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [31:0] issue_instr = '0;
    logic [63:0] issue_base = '0;
    logic [63:0] issue_data = '0;
    logic        mem_req;
    logic        mem_gnt;
    logic        mem_we;
    logic [63:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata;
    logic        done;
    logic        wb_valid;
    logic [4:0]  wb_rd;
    logic [63:0] wb_data;
    logic        fault_misaligned;
    logic        fault_illegal;

    int checks = 0;
    int fails  = 0;

    // memory model state
    logic [63:0] mem [DEPTH];
    logic [63:0] rdata_q;
    int          stall_cnt;
    int          gnt_delay = 0;
    int          req_count;
    logic [63:0] last_addr;
    logic [7:0]  last_be;
    logic        last_we;

    // bench-side expected memory
    logic [63:0] exp_mem [DEPTH];

    // captured outcome of the last operation
    logic        c_wbv, c_mis, c_ill;
    logic [63:0] c_data;
    logic [4:0]  c_rd;
    int          c_req_cycles;
    logic        c_addr_moved;

    // busy-window intruder
    logic        hold_busy = 1'b0;
    logic [31:0] busy_instr = '0;
    logic [63:0] busy_base = '0;
    logic [63:0] busy_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rv64_dw_lsu uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .issue_valid      (issue_valid),
        .issue_ready      (issue_ready),
        .issue_instr      (issue_instr),
        .issue_base       (issue_base),
        .issue_data       (issue_data),
        .mem_req          (mem_req),
        .mem_gnt          (mem_gnt),
        .mem_we           (mem_we),
        .mem_addr         (mem_addr),
        .mem_be           (mem_be),
        .mem_wdata        (mem_wdata),
        .mem_rdata        (mem_rdata),
        .done             (done),
        .wb_valid         (wb_valid),
        .wb_rd            (wb_rd),
        .wb_data          (wb_data),
        .fault_misaligned (fault_misaligned),
        .fault_illegal    (fault_illegal)
    );

    function automatic logic [63:0] pat(input int i);
        return {16'hC0DE, 12'h000, 4'(i), 24'h876543, 4'h0, 4'(i)};
    endfunction

    function automatic logic [31:0] enc_load(input logic [2:0] f3, input logic [4:0] rd,
                                             input logic [11:0] imm);
        return {imm, 5'd1, f3, rd, 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_store(input logic [2:0] f3, input logic [11:0] imm);
        return {imm[11:5], 5'd2, 5'd1, f3, imm[4:0], 7'b0100011};
    endfunction

    assign mem_gnt   = mem_req && (stall_cnt >= gnt_delay);
    assign mem_rdata = rdata_q;

    // Behavioural memory: writes by byte enable, reads registered on grant.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
            rdata_q   <= '0;
            stall_cnt <= 0;
            req_count <= 0;
            last_addr <= '0;
            last_be   <= '0;
            last_we   <= 1'b0;
        end else begin
            if (mem_req && !mem_gnt) stall_cnt <= stall_cnt + 1;
            else                     stall_cnt <= 0;
            if (mem_req && mem_gnt) begin
                req_count <= req_count + 1;
                last_addr <= mem_addr;
                last_be   <= mem_be;
                last_we   <= mem_we;
                if (mem_we) begin
                    for (int b = 0; b < 8; b++)
                        if (mem_be[b]) mem[mem_addr[6:3]][8*b +: 8] <= mem_wdata[8*b +: 8];
                end else begin
                    rdata_q <= mem[mem_addr[6:3]];
                end
            end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one instruction and wait for done; lat counts edges to done.
    task automatic run_op(input logic [31:0] ins, input logic [63:0] b,
                          input logic [63:0] d, output int lat);
        logic [63:0] first_addr;
        logic        have_addr;
        @(negedge clk);
        check("R8 ready before issue", 64'(issue_ready), 64'd1);
        issue_instr = ins;
        issue_base  = b;
        issue_data  = d;
        issue_valid = 1'b1;
        @(negedge clk);
        if (hold_busy) begin
            issue_instr = busy_instr;
            issue_base  = busy_base;
            issue_data  = busy_data;
        end else begin
            issue_valid = 1'b0;
        end
        lat = 1;
        c_req_cycles = 0;
        c_addr_moved = 1'b0;
        have_addr = 1'b0;
        first_addr = '0;
        while (!done && lat < 60) begin
            if (mem_req) begin
                c_req_cycles++;
                if (!have_addr) begin
                    first_addr = mem_addr;
                    have_addr = 1'b1;
                end else if (mem_addr !== first_addr) begin
                    c_addr_moved = 1'b1;
                end
                if (hold_busy)
                    check("R8 ready low while busy", 64'(issue_ready), 64'd0);
            end
            @(negedge clk);
            lat++;
        end
        issue_valid = 1'b0;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R9 no done: actual 0 expected 1");
        end
        c_wbv  = wb_valid;
        c_mis  = fault_misaligned;
        c_ill  = fault_illegal;
        c_data = wb_data;
        c_rd   = wb_rd;
    endtask

    task automatic t_reset();
        check("R1 ready", 64'(issue_ready), 64'd1);
        check("R1 mem_req", 64'(mem_req), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 outcome flags", {61'd0, wb_valid, fault_misaligned, fault_illegal}, 64'd0);
    endtask

    task automatic t_load_dword();
        int lat;
        run_op(enc_load(3'b011, 5'd7, 12'h018), 64'h1000, 64'd0, lat);
        check("R2 ld address", last_addr, 64'h1018);
        check("R2 ld be", 64'(last_be), 64'hFF);
        check("R2 ld we", 64'(last_we), 64'd0);
        check("R2 ld data", c_data, exp_mem[3]);
        check("R2 ld rd", 64'(c_rd), 64'd7);
        check("R2 ld wb_valid", 64'(c_wbv), 64'd1);
        check("R9 ld latency", 64'(lat), 64'd3);
    endtask

    task automatic t_neg_offset_load();
        int lat;
        run_op(enc_load(3'b011, 5'd9, 12'hFF8), 64'h1040, 64'd0, lat);
        check("R5 negative load offset", last_addr, 64'h1038);
        check("R5 negative load data", c_data, exp_mem[7]);
    endtask

    task automatic t_load_word();
        int lat;
        run_op(enc_load(3'b110, 5'd3, 12'h000), 64'h1020, 64'd0, lat);
        check("R3 lower lane be", 64'(last_be), 64'h0F);
        check("R3 lower lane zext", c_data, {32'd0, exp_mem[4][31:0]});
        run_op(enc_load(3'b110, 5'd4, 12'h004), 64'h1020, 64'd0, lat);
        check("R3 upper lane be", 64'(last_be), 64'hF0);
        check("R3 upper lane zext", c_data, {32'd0, exp_mem[4][63:32]});
        check("R3 word rd", 64'(c_rd), 64'd4);
    endtask

    task automatic t_store();
        int lat;
        int n0;
        run_op(enc_store(3'b011, 12'h028), 64'h1000, 64'h0123_4567_89AB_CDEF, lat);
        exp_mem[5] = 64'h0123_4567_89AB_CDEF;
        check("R4 sd address", last_addr, 64'h1028);
        check("R4 sd we", 64'(last_we), 64'd1);
        check("R4 sd be", 64'(last_be), 64'hFF);
        check("R4 sd no wb", 64'(c_wbv), 64'd0);
        check("R9 sd latency", 64'(lat), 64'd2);
        @(negedge clk);
        check("R4 sd memory", mem[5], exp_mem[5]);
        run_op(enc_load(3'b011, 5'd1, 12'h028), 64'h1000, 64'd0, lat);
        check("R4 sd readback", c_data, exp_mem[5]);
        run_op(enc_store(3'b011, 12'h5A8), 64'h0, 64'hFEED_0000_0000_BEEF, lat);
        exp_mem[5] = 64'hFEED_0000_0000_BEEF;
        check("R4 split offset address", last_addr, 64'h5A8);
        run_op(enc_store(3'b011, 12'hFF0), 64'h1080, 64'h1111_2222_3333_4444, lat);
        exp_mem[14] = 64'h1111_2222_3333_4444;
        check("R5 negative store offset", last_addr, 64'h1070);
        n0 = req_count;
        run_op(enc_load(3'b011, 5'd2, 12'h070), 64'h1000, 64'd0, lat);
        check("R5 store readback", c_data, exp_mem[14]);
        check("R4 one request per op", 64'(req_count - n0), 64'd1);
    endtask

    task automatic t_misaligned();
        int lat;
        int n0;
        n0 = req_count;
        run_op(enc_load(3'b011, 5'd5, 12'h004), 64'h1000, 64'd0, lat);
        check("R6 ld misaligned flag", 64'(c_mis), 64'd1);
        check("R9 fault latency", 64'(lat), 64'd1);
        run_op(enc_load(3'b110, 5'd5, 12'h002), 64'h1020, 64'd0, lat);
        check("R6 word misaligned flag", 64'(c_mis), 64'd1);
        run_op(enc_store(3'b011, 12'h001), 64'h1000, 64'hDEAD, lat);
        check("R6 sd misaligned flag", 64'(c_mis), 64'd1);
        check("R6 no request", 64'(req_count - n0), 64'd0);
        @(negedge clk);
        check("R6 memory untouched", mem[0], exp_mem[0]);
        run_op(enc_load(3'b110, 5'd5, 12'h004), 64'h1000, 64'd0, lat);
        check("R6 aligned word ok", {62'd0, c_mis, c_wbv}, 64'd1);
    endtask

    task automatic t_illegal();
        int lat;
        int n0;
        n0 = req_count;
        run_op(enc_load(3'b010, 5'd5, 12'h000), 64'h1000, 64'd0, lat);
        check("R7 load funct3 illegal", 64'(c_ill), 64'd1);
        run_op(enc_store(3'b010, 12'h001), 64'h1000, 64'd0, lat);
        check("R7 store funct3 illegal, no misaligned", {62'd0, c_ill, c_mis}, 64'd2);
        run_op({12'h000, 5'd1, 3'b011, 5'd5, 7'b0010011}, 64'h1000, 64'd0, lat);
        check("R7 other opcode illegal", 64'(c_ill), 64'd1);
        check("R7 no request", 64'(req_count - n0), 64'd0);
    endtask

    task automatic t_stall();
        int lat;
        gnt_delay = 3;
        run_op(enc_load(3'b011, 5'd6, 12'h010), 64'h1000, 64'd0, lat);
        check("R8 stalled data", c_data, exp_mem[2]);
        check("R8 request held cycles", 64'(c_req_cycles), 64'd4);
        check("R8 address stable", 64'(c_addr_moved), 64'd0);
        check("R9 stalled latency", 64'(lat), 64'd6);
        gnt_delay = 0;
    endtask

    task automatic t_busy();
        int lat;
        int n0;
        n0 = req_count;
        gnt_delay  = 2;
        hold_busy  = 1'b1;
        busy_instr = enc_store(3'b011, 12'h000);
        busy_base  = 64'h1008;
        busy_data  = 64'hBAD0_BAD0_BAD0_BAD0;
        run_op(enc_load(3'b011, 5'd8, 12'h030), 64'h1000, 64'd0, lat);
        hold_busy = 1'b0;
        gnt_delay = 0;
        check("R8 busy load data", c_data, exp_mem[6]);
        check("R8 busy single request", 64'(req_count - n0), 64'd1);
        @(negedge clk);
        check("R8 intruder ignored", mem[1], exp_mem[1]);
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = pat(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_dword();
        t_neg_offset_load();
        t_load_word();
        t_store();
        t_misaligned();
        t_illegal();
        t_stall();
        t_busy();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule